// File: doc/BRIEF.md
# Programmable Square-Wave Clock Output

This block turns a timer into a square-wave generator. A 16-bit up-counter advances on a count-enable tick. Each time it passes its all-ones value it wraps, reloads itself from a stored reload value and flips the output level. Because the level flips once per wrap, the output has exactly equal high and low times.

The tick comes from a small prescaler. The prescaler fires every oscillator cycle in the fast rate mode and every second cycle in the slow rate mode. The full output period is therefore n × (65536 − R) oscillator cycles, where R is the reload value, n is 2 in the fast mode and 4 in the slow mode. At a 16 MHz oscillator this spans 122 Hz to 8 MHz in fast mode and 61 Hz to 4 MHz in slow mode.

Square-wave generation happens only when three things hold together: the timer is selected (not event counting), the output is enabled and the run bit is set. A wrap that happens while the output is enabled never requests an interrupt. When the output is disabled, the pin rests high like an idle general-purpose pin, and wraps of a running timer raise the interrupt request instead.

Top module: `clkout_gen`

## Requirements
- R1: After reset, `clk_out` is 1 and `ovf_pulse` and `irq_req` are 0. The internal output level starts at 1, and the counter starts at all-ones.
- R2: With the timer running and the output enabled, every half period of `clk_out` lasts P × (65536 − R) clock cycles. P is 1 when `cfg_slow` = 0 and 2 when `cfg_slow` = 1.
- R3: A reload value written with `reload_wr` = 1 is used only from the next wrap onward. The half period already in progress keeps its length.
- R4: The counter advances only while `cfg_evt_count` = 0 and `cfg_run` = 1. With `cfg_evt_count` = 1 there are no wraps, no `ovf_pulse` and no change on `clk_out`.
- R5: While `cfg_out_en` = 0, `clk_out` is held at 1.
- R6: When `cfg_run` = 0, counting stops. `clk_out` holds its level and no `ovf_pulse` occurs. Counting resumes from the held count when `cfg_run` returns to 1.
- R7: `irq_req` pulses for one cycle on a wrap only when `cfg_out_en` = 0. A wrap with `cfg_out_en` = 1 never raises `irq_req`.
- R8: `ovf_pulse` is high for the one cycle after each wrap. In clock-out operation, `clk_out` changes level in exactly those cycles.
- R9: Because the counter starts at all-ones, the first tick after start-up wraps. `clk_out` goes to 0 one clock after `cfg_run` is set. The first flip does not wait for a full period.
- R10: With R = 16'hFFFF, every tick wraps. In fast mode `clk_out` therefore flips every clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_evt_count | input | 1 | 1 selects event counting (no counting here), 0 selects timer |
| cfg_out_en | input | 1 | 1 routes the square wave to `clk_out` |
| cfg_run | input | 1 | 1 lets the timer count |
| cfg_slow | input | 1 | 0: tick every cycle (n=2); 1: tick every second cycle (n=4) |
| reload_wr | input | 1 | Write strobe for `reload_val` |
| reload_val | input | 16 | New reload value |
| clk_out | output | 1 | Square-wave output, 1 when disabled |
| ovf_pulse | output | 1 | One-cycle pulse after each wrap |
| irq_req | output | 1 | Timer interrupt request, never raised in clock-out operation |

## Verification
The bench aims at the wrap boundary. It checks that a design which loads zero instead of R, or which loads a freshly written reload value at once, gives a wrong half period around a mid-period write. It switches the rate mode while running to catch a prescaler whose divide is off by one, which would show up as half periods of 16 versus 32 cycles being wrong. It stops the run bit mid-period, drops the output enable and selects event counting, so that a design which keeps toggling, lets the pin float low or raises an interrupt during clock-out operation is caught. The highest-frequency case (R = all-ones) and the first flip after reset expose a counter that resets to zero or misses the wrap on back-to-back ticks.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    // Rate selection seen on cfg_slow
    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;

    // Registered output-side state of the top level
    typedef struct packed {
        logic level;   // square-wave level
        logic wrap;    // wrap seen on previous edge
        logic irq;     // interrupt request pulse
    } pin_state_t;

endpackage

// File: rtl/clkout_prescaler.sv
module clkout_prescaler #(
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic slow,
    output logic tick
);
    import clkout_pkg::*;

    localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PW   = (MAXD > 1) ? $clog2(MAXD) : 1;
    localparam logic [PW-1:0] FAST_LAST = PW'(FAST_DIV - 1);
    localparam logic [PW-1:0] SLOW_LAST = PW'(SLOW_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [PW-1:0] last;

    always_comb begin
        pre_d = pre_q;
        tick  = 1'b0;
        last  = (rate_e'(slow) == RATE_SLOW) ? SLOW_LAST : FAST_LAST;
        if (!enable) begin
            pre_d.phase = '0;
        end else if (pre_q.phase >= last) begin
            pre_d.phase = '0;
            tick        = 1'b1;
        end else begin
            pre_d.phase = pre_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/clkout_counter.sv
module clkout_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_val,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;     // running count
        logic [CNT_W-1:0] reload;  // value loaded at the next wrap
    } ctr_t;

    localparam ctr_t CTR_RESET = '{cnt: '1, reload: '0};

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        wrap  = 1'b0;
        if (tick) begin
            if (ctr_q.cnt == '1) begin
                ctr_d.cnt = ctr_q.reload;
                wrap      = 1'b1;
            end else begin
                ctr_d.cnt = ctr_q.cnt + CNT_W'(1);
            end
        end
        // a write lands in the holding register; the count picks it up on the next wrap
        if (reload_wr) ctr_d.reload = reload_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= CTR_RESET;
        else        ctr_q <= ctr_d;
    end

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen #(
    parameter int CNT_W    = 16,
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_evt_count,
    input  logic             cfg_out_en,
    input  logic             cfg_run,
    input  logic             cfg_slow,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_val,
    output logic             clk_out,
    output logic             ovf_pulse,
    output logic             irq_req
);
    import clkout_pkg::*;

    localparam pin_state_t PIN_RESET = '{level: 1'b1, wrap: 1'b0, irq: 1'b0};

    logic       run_en;
    logic       tick;
    logic       wrap;
    pin_state_t pin_d, pin_q;

    assign run_en = cfg_run & ~cfg_evt_count;

    clkout_prescaler #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (run_en),
        .slow   (cfg_slow),
        .tick   (tick)
    );

    clkout_counter #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .reload_wr  (reload_wr),
        .reload_val (reload_val),
        .wrap       (wrap)
    );

    always_comb begin
        pin_d      = pin_q;
        pin_d.wrap = wrap;
        pin_d.irq  = wrap & ~cfg_out_en;
        if (wrap && cfg_out_en) pin_d.level = ~pin_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= PIN_RESET;
        else        pin_q <= pin_d;
    end

    assign clk_out   = cfg_out_en ? pin_q.level : 1'b1;
    assign ovf_pulse = pin_q.wrap;
    assign irq_req   = pin_q.irq;

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_evt_count,
    input logic cfg_out_en,
    input logic cfg_run,
    input logic clk_out,
    input logic ovf_pulse,
    input logic irq_req
);

    // R7: an interrupt pulse may only follow a cycle with the output disabled
    assert_irq_only_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(cfg_out_en));

    // R7: an interrupt pulse is always accompanied by a wrap pulse
    assert_irq_with_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ovf_pulse);

    // R4: event-count selection suppresses wraps
    assert_no_wrap_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_evt_count) |-> !ovf_pulse);

    // R6: no wrap after a cycle with run low
    assert_no_wrap_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_run) |-> !ovf_pulse);

    // R6: pin holds its level while stopped
    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_run) && $stable(cfg_out_en)) |-> $stable(clk_out));

    // R8: with enable steady, the pin only changes together with a wrap pulse
    assert_flip_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(clk_out) && $stable(cfg_out_en)) |-> ovf_pulse);

endmodule

bind clkout_gen clkout_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_evt_count (cfg_evt_count),
    .cfg_out_en    (cfg_out_en),
    .cfg_run       (cfg_run),
    .clk_out       (clk_out),
    .ovf_pulse     (ovf_pulse),
    .irq_req       (irq_req)
);

// File: tb/sim_clkout_gen.sv
`timescale 1ns/1ps
module sim_clkout_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_evt_count = 1'b0;
    logic        cfg_out_en = 1'b0;
    logic        cfg_run = 1'b0;
    logic        cfg_slow = 1'b0;
    logic        reload_wr = 1'b0;
    logic [15:0] reload_val = 16'h0000;
    logic        clk_out, ovf_pulse, irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    clkout_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_evt_count(cfg_evt_count),
        .cfg_out_en(cfg_out_en), .cfg_run(cfg_run), .cfg_slow(cfg_slow),
        .reload_wr(reload_wr), .reload_val(reload_val),
        .clk_out(clk_out), .ovf_pulse(ovf_pulse), .irq_req(irq_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model and monitor
    int  m_phase = 0;
    int  m_cnt   = 65535;
    int  m_rel   = 0;
    bit  m_level = 1;
    bit  m_wrap  = 0;
    bit  m_irq   = 0;
    int  cyc = 0;
    int  last_edge = 0;
    int  last_half = 0;
    int  edges_seen = 0;
    int  ovf_seen = 0;
    int  irq_seen = 0;
    bit  prev_out = 1;

    always @(posedge clk) begin
        bit w;
        int lim;
        cyc++;
        w = 0;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 65535; m_rel = 0; m_level = 1; m_wrap = 0; m_irq = 0;
        end else begin
            lim = cfg_slow ? 2 : 1;
            if (cfg_run && !cfg_evt_count) begin
                m_phase++;
                if (m_phase >= lim) begin
                    m_phase = 0;
                    if (m_cnt == 65535) begin m_cnt = m_rel; w = 1; end
                    else m_cnt++;
                end
            end else m_phase = 0;
            m_wrap = w;
            m_irq  = w && !cfg_out_en;
            if (w && cfg_out_en) m_level = !m_level;
            if (reload_wr) m_rel = int'(reload_val);
        end
        #1;
        if (rst_n) begin
            chk(clk_out == (cfg_out_en ? m_level : 1'b1), "R2", "model clk_out", clk_out, cfg_out_en ? m_level : 1);
            chk(ovf_pulse == m_wrap, "R8", "model ovf_pulse", ovf_pulse, m_wrap);
            chk(irq_req == m_irq, "R7", "model irq_req", irq_req, m_irq);
        end
        if (clk_out != prev_out) begin
            edges_seen++;
            last_half = cyc - last_edge;
            last_edge = cyc;
        end
        prev_out = clk_out;
        ovf_seen += int'(ovf_pulse);
        irq_seen += int'(irq_req);
    end

    task automatic wait_edges(input int n);
        int target;
        target = edges_seen + n;
        while (edges_seen < target) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic write_reload(input logic [15:0] v);
        @(negedge clk);
        reload_val = v; reload_wr = 1'b1;
        @(negedge clk);
        reload_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_run = 0; cfg_out_en = 0; cfg_evt_count = 0; cfg_slow = 0; reload_wr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s_ovf, s_irq, s_edge;
        bit held;
        do_reset();
        @(posedge clk); #1;
        chk(clk_out == 1'b1, "R1", "reset clk_out", clk_out, 1);
        chk(ovf_pulse == 1'b0, "R1", "reset ovf_pulse", ovf_pulse, 0);
        chk(irq_req == 1'b0, "R1", "reset irq_req", irq_req, 0);

        // R9: first tick after start wraps
        write_reload(16'hFFF0);
        @(negedge clk);
        cfg_out_en = 1; cfg_run = 1;
        @(posedge clk); #1;
        chk(clk_out == 1'b0, "R9", "first flip", clk_out, 0);
        chk(ovf_pulse == 1'b1, "R9", "first wrap pulse", ovf_pulse, 1);

        // R2 fast mode: half period 16
        wait_edges(3);
        chk(last_half == 16, "R2", "fast half period", last_half, 16);

        // R2 slow mode: half period 32
        @(negedge clk); cfg_slow = 1;
        wait_edges(3);
        chk(last_half == 32, "R2", "slow half period", last_half, 32);

        // R3: write mid-period, only the next half uses it
        wait_edges(1);
        reload_val = 16'hFFF8; reload_wr = 1'b1;
        @(negedge clk); reload_wr = 1'b0;
        wait_edges(1);
        chk(last_half == 32, "R3", "half in progress", last_half, 32);
        wait_edges(1);
        chk(last_half == 16, "R3", "half after write", last_half, 16);

        // R8: pulses match flips in clock-out operation
        s_ovf = ovf_seen; s_edge = edges_seen;
        repeat (60) @(negedge clk);
        chk((ovf_seen - s_ovf) == (edges_seen - s_edge), "R8", "wraps vs flips",
            ovf_seen - s_ovf, edges_seen - s_edge);

        // R7: no interrupt while clock-out is active
        chk(irq_seen == 0, "R7", "irq in clock-out", irq_seen, 0);

        // R10: all-ones reload, fast: flip every cycle
        write_reload(16'hFFFF);
        @(negedge clk); cfg_slow = 0;
        wait_edges(4);
        chk(last_half == 1, "R10", "max rate half period", last_half, 1);

        // R6: stop, level holds, no wraps
        write_reload(16'hFFE0);
        wait_edges(2);
        @(negedge clk); cfg_run = 0;
        @(posedge clk); #1;
        held = clk_out; s_ovf = ovf_seen; s_edge = edges_seen;
        repeat (50) @(negedge clk);
        chk(clk_out == held, "R6", "level while stopped", clk_out, held);
        chk(ovf_seen == s_ovf, "R6", "wraps while stopped", ovf_seen - s_ovf, 0);
        @(negedge clk); cfg_run = 1;
        wait_edges(2);
        chk(last_half == 32, "R6", "half after restart", last_half, 32);

        // R5 / R7: output disabled while running
        @(negedge clk); cfg_out_en = 0;
        s_ovf = ovf_seen; s_irq = irq_seen;
        repeat (100) @(negedge clk);
        chk(clk_out == 1'b1, "R5", "pin idle high", clk_out, 1);
        chk((irq_seen - s_irq) > 0, "R7", "irq when disabled", irq_seen - s_irq, 3);
        chk((irq_seen - s_irq) == (ovf_seen - s_ovf), "R7", "irq per wrap",
            irq_seen - s_irq, ovf_seen - s_ovf);

        // R4: event-count select stops everything
        @(negedge clk); cfg_out_en = 1; cfg_evt_count = 1;
        @(posedge clk); #1;
        held = clk_out; s_ovf = ovf_seen;
        repeat (80) @(negedge clk);
        chk(ovf_seen == s_ovf, "R4", "wraps in event mode", ovf_seen - s_ovf, 0);
        chk(clk_out == held, "R4", "pin in event mode", clk_out, held);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule